// File: doc/BRIEF.md
# Serial Frame Aligner and Splitter

This block sits at the front of a downstream receive path. It takes one serial data bit per clock and finds where frames begin. A frame starts with a two-byte framing word that is sent least significant bit first. Once the frame position is known, the block rebuilds bytes and sorts them into two byte streams, each with its own one-cycle strobe. The first stream is the frame header. The second is the payload that goes on to the error-correction stages. The framing bytes themselves are dropped. The same clock samples the serial input and runs all of the logic.

Alignment has three phases. While hunting, the block compares the last sixteen received bits with the framing word at every bit position. A first match only opens a confirmation window. In-frame is declared when the word appears again exactly one frame length later. While locked, the word is checked once per frame at its expected position. A run of consecutive failed checks drops the lock and starts the bit-level hunt again. Bytes are only put out while the block is locked. With the default sizes, a frame is 2 framing bytes, then 16 header bytes, then 792 payload bytes (12 blocks of 66), for 810 bytes in all.

Top module: `sfa_aligner`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `in_frame`, `hdr_valid` and `pay_valid` are 0 and `byte_out` is 0.
- R2: Each output byte is built so that the first serial bit received for that byte appears on `byte_out[0]` and the last one on `byte_out[7]`.
- R3: While hunting, the framing word is found at any bit offset. It matches when its bit 0 is the earliest of the sixteen bits received. A first match sends the block into confirmation, and no strobe is issued during confirmation.
- R4: `in_frame` rises only when the framing word is found again exactly FRAME_BITS = 8*(SYNC_BYTES+HDR_BYTES+PAY_BYTES) bits after the first match. If it is not found there, the block goes back to hunting and `in_frame` stays 0.
- R5: `in_frame` is high for the whole body of the frame whose framing word confirmed the alignment.
- R6: In a locked frame, the two framing bytes are never strobed. The next HDR_BYTES bytes appear in order with `hdr_valid`. The next PAY_BYTES bytes appear in order with `pay_valid`. The two strobes are never high together, and strobes are never high in two consecutive cycles.
- R7: `hdr_valid` and `pay_valid` are high only while `in_frame` is high.
- R8: While locked, up to LOSS_LIMIT-1 (default 3) consecutive failed framing checks keep `in_frame` high, and those frames are still put out. One good check clears the run. The LOSS_LIMIT-th consecutive failure (default 4) lowers `in_frame` at that check, and nothing from that frame is put out.
- R9: After lock is lost, hunting restarts. The block relocks on a stream placed at a new bit offset.
- R10: While locked, a copy of the framing word inside header or payload data, whether byte-aligned or not, changes neither the alignment nor the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; samples `ser_bit` and runs the block |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial downstream data, one bit per clock |
| in_frame | output | 1 | High while frame alignment is held |
| hdr_valid | output | 1 | One-cycle strobe: `byte_out` holds a header byte |
| pay_valid | output | 1 | One-cycle strobe: `byte_out` holds a payload byte |
| byte_out | output | 8 | Most recently completed aligned byte |

## Verification
While locked, the bit-level sync comparator keeps running. So a copy of the framing word inside the payload can produce a match in the same cycle that a payload byte completes and is strobed. The bench provokes this by placing the word in the payload once on a byte boundary and once three bits off a boundary. It then judges that every payload byte still comes out in order with `pay_valid`, and that `in_frame` stays high. A second meeting point is the framing check at the frame boundary, which decides lock loss while the previous frame's last payload strobe has just been issued. Here the bench checks that the frame's data is put out for three failed checks and dropped on the fourth.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  typedef enum logic [1:0] {
    ALN_HUNT    = 2'd0,
    ALN_CONFIRM = 2'd1,
    ALN_LOCKED  = 2'd2
  } aln_state_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_HDR  = 2'd1,
    SEG_PAY  = 2'd2
  } seg_t;

  function automatic int unsigned frame_bits(int unsigned sync_b, int unsigned hdr_b,
                                             int unsigned pay_b);
    return 8 * (sync_b + hdr_b + pay_b);
  endfunction

endpackage

// File: rtl/sfa_window.sv
module sfa_window #(
  parameter int                  SYNC_BYTES = 2,
  parameter logic [8*SYNC_BYTES-1:0] SYNC_WORD = 16'hA6C4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_bit,
  output logic       hit,
  output logic [7:0] last_byte
);
  localparam int W  = 8 * SYNC_BYTES;
  localparam int FW = $clog2(W + 1);
  localparam logic [FW-1:0] FILL_FULL = FW'(W);

  logic [W-1:0]  win;
  logic [FW-1:0] fill;

  // newest bit enters at the top, so the earliest bit sits at bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      win  <= '0;
      fill <= '0;
    end else begin
      win <= {ser_bit, win[W-1:1]};
      if (fill != FILL_FULL) fill <= fill + 1'b1;
    end
  end

  always_comb begin
    hit       = (fill == FILL_FULL) && (win == SYNC_WORD);
    last_byte = win[W-1 -: 8];
  end

endmodule

// File: rtl/sfa_position.sv
module sfa_position
  import sfa_pkg::*;
#(
  parameter int SYNC_BYTES = 2,
  parameter int HDR_BYTES  = 16,
  parameter int PAY_BYTES  = 792
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic at_check,
  output logic byte_done,
  output seg_t seg
);
  localparam int FRAME_BITS = frame_bits(SYNC_BYTES, HDR_BYTES, PAY_BYTES);
  localparam int PW         = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] SYNC_END = PW'(8 * SYNC_BYTES - 1);
  localparam logic [PW-1:0] HDR_END  = PW'(8 * (SYNC_BYTES + HDR_BYTES) - 1);
  localparam logic [PW-1:0] RELOAD   = PW'(8 * SYNC_BYTES);

  // pos = frame index of the bit most recently shifted into the window
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)                 pos <= '0;
    else if (load)           pos <= RELOAD;
    else if (pos == POS_LAST) pos <= '0;
    else                     pos <= pos + 1'b1;
  end

  always_comb begin
    at_check  = (pos == SYNC_END);
    byte_done = &pos[2:0];
    if (pos <= SYNC_END)     seg = SEG_SYNC;
    else if (pos <= HDR_END) seg = SEG_HDR;
    else                     seg = SEG_PAY;
  end

endmodule

// File: rtl/sfa_lock_fsm.sv
module sfa_lock_fsm
  import sfa_pkg::*;
#(
  parameter int LOSS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic at_check,
  output logic load,
  output logic locked
);
  localparam int MW = (LOSS_LIMIT > 1) ? $clog2(LOSS_LIMIT) : 1;
  localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_LIMIT - 1);

  aln_state_t    st;
  logic [MW-1:0] miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ALN_HUNT;
      miss <= '0;
    end else begin
      unique case (st)
        ALN_HUNT: begin
          miss <= '0;
          if (hit) st <= ALN_CONFIRM;
        end
        ALN_CONFIRM: begin
          if (at_check) st <= hit ? ALN_LOCKED : ALN_HUNT;
        end
        ALN_LOCKED: begin
          if (at_check) begin
            if (hit) begin
              miss <= '0;
            end else if (miss == MISS_LAST) begin
              miss <= '0;
              st   <= ALN_HUNT;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
        default: st <= ALN_HUNT;
      endcase
    end
  end

  always_comb begin
    load   = (st == ALN_HUNT) && hit;
    locked = (st == ALN_LOCKED);
  end

endmodule

// File: rtl/sfa_aligner.sv
module sfa_aligner
  import sfa_pkg::*;
#(
  parameter int                      SYNC_BYTES = 2,
  parameter int                      HDR_BYTES  = 16,
  parameter int                      PAY_BYTES  = 792,
  parameter int                      LOSS_LIMIT = 4,
  parameter logic [8*SYNC_BYTES-1:0] SYNC_WORD  = 16'hA6C4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_bit,
  output logic       in_frame,
  output logic       hdr_valid,
  output logic       pay_valid,
  output logic [7:0] byte_out
);
  logic       hit, load, at_check, byte_done, locked, emit;
  logic [7:0] last_byte;
  seg_t       seg;

  sfa_window #(.SYNC_BYTES(SYNC_BYTES), .SYNC_WORD(SYNC_WORD)) u_window (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .hit(hit), .last_byte(last_byte)
  );

  sfa_position #(.SYNC_BYTES(SYNC_BYTES), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) u_pos (
    .clk(clk), .rst(rst), .load(load), .at_check(at_check), .byte_done(byte_done), .seg(seg)
  );

  sfa_lock_fsm #(.LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
    .clk(clk), .rst(rst), .hit(hit), .at_check(at_check), .load(load), .locked(locked)
  );

  assign in_frame = locked;
  assign emit     = locked && byte_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      byte_out  <= '0;
    end else begin
      hdr_valid <= emit && (seg == SEG_HDR);
      pay_valid <= emit && (seg == SEG_PAY);
      if (emit && (seg != SEG_SYNC)) byte_out <= last_byte;
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && pay_valid));

  p_strobe_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || pay_valid) |=> !(hdr_valid || pay_valid));

  p_strobe_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || pay_valid) |-> in_frame);

  p_gain_at_check_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> $past(at_check && hit));

  p_loss_at_check_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(in_frame) |-> $past(at_check && !hit));

endmodule

// File: tb/test_sfa_aligner.sv
module test_sfa_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 2;
  localparam int HB = 16;
  localparam int PB = 64;
  localparam int FBITS = 8 * (SB + HB + PB);
  localparam logic [15:0] PAT = 16'hA6C4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_bit = 1'b0;
  logic in_frame, hdr_valid, pay_valid;
  logic [7:0] byte_out;

  int checks = 0;
  int errors = 0;
  int both_cnt = 0;
  int stray_cnt = 0;
  bit done = 1'b0;
  string pend_tag = "R6";

  logic [7:0] got_hdr[$], got_pay[$], exp_hdr[$], exp_pay[$];
  logic [7:0] fh[HB];
  logic [7:0] fp[PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfa_aligner #(.SYNC_BYTES(SB), .HDR_BYTES(HB), .PAY_BYTES(PB), .LOSS_LIMIT(4),
                .SYNC_WORD(PAT)) i_sfa_aligner (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .in_frame(in_frame),
    .hdr_valid(hdr_valid), .pay_valid(pay_valid), .byte_out(byte_out)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_valid) got_hdr.push_back(byte_out);
      if (pay_valid) got_pay.push_back(byte_out);
      if (hdr_valid && pay_valid) both_cnt++;
      if ((hdr_valid || pay_valid) && !in_frame) stray_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_bit = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  // modes: 0 random, 1 zeros, 2 aligned word in payload, 3 unaligned word, 4 bit-order bytes
  task automatic fill_frame(input int mode);
    logic [23:0] sh;
    for (int i = 0; i < HB; i++) fh[i] = (mode == 1) ? 8'h00 : 8'($urandom);
    for (int i = 0; i < PB; i++) fp[i] = (mode == 1) ? 8'h00 : 8'($urandom);
    sh = {8'h00, PAT} << 3;
    if (mode == 2) begin fp[5] = PAT[7:0]; fp[6] = PAT[15:8]; fh[3] = PAT[7:0]; fh[4] = PAT[15:8]; end
    if (mode == 3) begin fp[20] = sh[7:0]; fp[21] = sh[15:8]; fp[22] = sh[23:16]; end
    if (mode == 4) begin fh[0] = 8'h01; fh[1] = 8'h80; fp[0] = 8'h01; fp[1] = 8'h80; end
  endtask

  task automatic check_stream();
    chk(got_hdr.size() == exp_hdr.size(), pend_tag, "header byte count", got_hdr.size(), exp_hdr.size());
    chk(got_pay.size() == exp_pay.size(), pend_tag, "payload byte count", got_pay.size(), exp_pay.size());
    if (got_hdr.size() == exp_hdr.size())
      foreach (exp_hdr[i]) chk(got_hdr[i] == exp_hdr[i], pend_tag, "header byte", got_hdr[i], exp_hdr[i]);
    if (got_pay.size() == exp_pay.size())
      foreach (exp_pay[i]) chk(got_pay[i] == exp_pay[i], pend_tag, "payload byte", got_pay[i], exp_pay[i]);
    got_hdr.delete(); got_pay.delete(); exp_hdr.delete(); exp_pay.delete();
  endtask

  task automatic send_frame(input bit good, input bit emit, input string tag);
    logic [15:0] sw;
    sw = good ? PAT : (PAT ^ 16'h0100);
    for (int i = 0; i < 16; i++) send_bit(sw[i]);
    check_stream();
    pend_tag = tag;
    if (emit) begin
      for (int i = 0; i < HB; i++) exp_hdr.push_back(fh[i]);
      for (int i = 0; i < PB; i++) exp_pay.push_back(fp[i]);
    end
    for (int i = 0; i < HB; i++) send_byte(fh[i]);
    for (int i = 0; i < PB; i++) send_byte(fp[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5FA1));
    repeat (4) @(negedge clk);
    chk(!in_frame && !hdr_valid && !pay_valid, "R1", "flags in reset", {in_frame, hdr_valid, pay_valid}, 0);
    chk(byte_out == 8'h00, "R1", "byte_out in reset", byte_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!in_frame && !hdr_valid && !pay_valid, "R1", "flags after release", {in_frame, hdr_valid, pay_valid}, 0);

    // lone framing word with no repeat one frame later
    for (int i = 0; i < 16; i++) send_bit(PAT[i]);
    for (int i = 0; i < FBITS; i++) send_bit(1'b0);
    chk(in_frame == 1'b0, "R4", "in_frame after failed confirm", in_frame, 0);
    repeat (40) send_bit(1'b0);
    chk(got_hdr.size() + got_pay.size() == 0, "R4", "strobes without lock", got_hdr.size() + got_pay.size(), 0);

    // arbitrary bit offset, then confirmation frame and locking frame
    repeat (3 + ($urandom % 8)) send_bit(1'b0);
    fill_frame(0);
    send_frame(1'b1, 1'b0, "R3");
    chk(in_frame == 1'b0, "R3", "in_frame while confirming", in_frame, 0);
    fill_frame(4);
    send_frame(1'b1, 1'b1, "R2");
    chk(in_frame == 1'b1, "R5", "in_frame after confirming frame", in_frame, 1);

    for (int k = 0; k < 4; k++) begin
      fill_frame((k == 1) ? 2 : (k == 2) ? 3 : 0);
      send_frame(1'b1, 1'b1, (k == 1 || k == 2) ? "R10" : "R6");
      chk(in_frame == 1'b1, "R10", "in_frame with word in data", in_frame, 1);
    end

    // tolerated misses, cleared by a good check
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 3; k++) begin
        fill_frame(0);
        send_frame(1'b0, 1'b1, "R8");
        chk(in_frame == 1'b1, "R8", "in_frame after tolerated miss", in_frame, 1);
      end
      fill_frame(0);
      send_frame(1'b1, 1'b1, "R8");
    end

    // loss on fourth consecutive miss
    for (int k = 0; k < 3; k++) begin
      fill_frame(0);
      send_frame(1'b0, 1'b1, "R8");
    end
    fill_frame(1);
    send_frame(1'b0, 1'b0, "R8");
    chk(in_frame == 1'b0, "R8", "in_frame after fourth miss", in_frame, 0);

    // relock at a new offset
    repeat (5 + ($urandom % 11)) send_bit(1'b0);
    fill_frame(0);
    send_frame(1'b1, 1'b0, "R9");
    chk(in_frame == 1'b0, "R9", "in_frame while reconfirming", in_frame, 0);
    fill_frame(0);
    send_frame(1'b1, 1'b1, "R9");
    chk(in_frame == 1'b1, "R9", "in_frame after relock", in_frame, 1);
    fill_frame(4);
    send_frame(1'b1, 1'b1, "R2");
    for (int i = 0; i < 16; i++) send_bit(PAT[i]);
    check_stream();

    chk(both_cnt == 0, "R6", "cycles with both strobes", both_cnt, 0);
    chk(stray_cnt == 0, "R7", "strobes while out of frame", stray_cnt, 0);
    summary();
  end

endmodule